// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and groups those quanta into CAN bit periods. It emits a strobe at the point where the bus is sampled and a strobe that marks the start of each bit. The bit-start strobe is also the point at which a transmitter may change its output. The bit length comes from a prescaler and three segment fields. Each field is programmed as its value minus one. The prescaler is split into a 6-bit low part and a 4-bit high part.

A recessive-to-dominant transition on the received line is used to keep the bit grid aligned with the sender. An edge late in the bit lengthens the segment before the sample point. An edge in the segment after the sample point shortens that segment. In both cases the change is capped by the programmed jump width. When the bus is idle, or when a hard-sync request is raised, a falling edge instead restarts the bit at once. A protocol engine uses the sampled bit and both strobes. Frame decoding lies outside this block.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick_o` pulses for one cycle every P+1 clock cycles, where P = `presc_hi_i`*64 + `presc_lo_i` (high part in bits 9..6, low part in bits 5..0).
- R2: With no falling edge on the line, a bit lasts 1 + (`ph1_len_i`+1) + (`ph2_len_i`+1) quanta, and consecutive `bit_start_o` pulses lie that many quanta apart. `bit_start_o` only pulses together with `tq_tick_o`, on the tick that ends the sync quantum.
- R3: `sample_o` pulses together with the tick that ends the last quantum of the first phase segment. With no edge, this is `ph1_len_i`+1 quanta after `bit_start_o`.
- R4: `rx_bit_o` takes the line value at the sample point and changes only in the cycle after `sample_o`. The line value is `rx_i` registered once. When no sample occurs, `rx_bit_o` holds.
- R5: Quantum positions count from 0, where 0 is the sync quantum. A falling edge in quantum p of the first phase segment (p = 1 .. `ph1_len_i`+1) lengthens that segment by min(p, `sjw_i`+1) quanta.
- R6: Let the phase error e be the number of quanta from the edge quantum to the end of the bit, counting the edge quantum. For a falling edge in the second phase segment: if e <= `sjw_i`+1, the edge quantum becomes the sync quantum of a new bit, and `bit_start_o` pulses on its tick. Otherwise the segment is shortened by `sjw_i`+1 quanta.
- R7: While `bus_idle_i` or `hard_sync_req_i` is high, a falling edge in any quantum makes that quantum the sync quantum of a new bit.
- R8: At most one resynchronisation takes effect between two sample points; later edges before the next sample are ignored. Without a hard sync, an edge in the sync quantum has no effect.
- R9: While reset is asserted, all strobes and `rx_bit_o` are 0. The first tick after reset ends a sync quantum and therefore carries `bit_start_o`.
- R10: A falling edge seen between ticks is held and is acted on at the next tick, as part of the quantum that tick ends.
- R11: A rising edge on `rx_i` never moves the bit grid.
- R12: A falling edge on `rx_i` applied before clock edge k counts in the quantum that is in progress between clock edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| presc_lo_i | input | 6 | Low bits of the prescaler value minus one |
| presc_hi_i | input | 4 | High bits of the prescaler value minus one |
| ph1_len_i | input | 4 | Quanta before the sample point, minus one |
| ph2_len_i | input | 3 | Quanta after the sample point, minus one |
| sjw_i | input | 2 | Jump width minus one |
| rx_i | input | 1 | Received bus line, 1 = recessive |
| hard_sync_req_i | input | 1 | Next falling edge restarts the bit |
| bus_idle_i | input | 1 | Bus idle; falling edges restart the bit |
| tq_tick_o | output | 1 | One-cycle pulse at the end of each quantum |
| sample_o | output | 1 | Sample-point strobe |
| rx_bit_o | output | 1 | Line value taken at the last sample point |
| bit_start_o | output | 1 | End of the sync quantum; transmit point |

## Verification
The assertions assume that the prescaler and segment fields stay constant outside reset. The tick-spacing and quanta-per-bit properties are only meaningful under that assumption. They also assume that `rx_i` has a defined level from the first cycle, so that the sampled-bit property can look two cycles back. The stimulus changes timing fields only while reset is held and drives `rx_i` high from time zero. It places every falling edge at a known quantum position, measured from an observed bit start, so each expected strobe cycle follows from the segment lengths and jump width alone.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int unsigned BRP_LO_W = 6;
  localparam int unsigned BRP_HI_W = 4;
  localparam int unsigned PH1_W    = 4;
  localparam int unsigned PH2_W    = 3;
  localparam int unsigned SJW_W    = 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_rst_sync.sv
module can_bt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int unsigned LO_W = 6,
  parameter int unsigned HI_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LO_W-1:0] lo_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = LO_W + HI_W;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             tick_q;

  assign div = {hi_i, lo_i};
  assign hit = (cnt_q >= div);

  always_comb begin
    if (hit) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= hit;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/can_bt_edge_det.sv
module can_bt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic line_o,
  output logic fall_o
);
  logic cur_q, prev_q;
  logic pend_q, pend_d;
  logic fall_now;

  assign fall_now = prev_q & ~cur_q;

  always_comb begin
    if (tick_i) pend_d = 1'b0;
    else        pend_d = pend_q | fall_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      cur_q  <= rx_i;
      prev_q <= cur_q;
      pend_q <= pend_d;
    end
  end

  assign line_o = cur_q;
  assign fall_o = fall_now | pend_q;
endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase
  import can_bt_pkg::*;
#(
  parameter int unsigned PH1_W = 4,
  parameter int unsigned PH2_W = 3,
  parameter int unsigned SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             hsync_en_i,
  input  logic             line_i,
  input  logic [PH1_W-1:0] ph1_i,
  input  logic [PH2_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             start_o,
  output logic             sample_o,
  output logic             bit_o
);
  localparam int unsigned QW = $clog2((2**PH1_W) + (2**SJW_W));

  seg_e          seg_q, seg_d;
  logic [QW-1:0] cnt_q, cnt_d;
  logic [QW-1:0] lim_q, lim_d;
  logic [QW-1:0] lim_eff;
  logic [QW-1:0] ph1_lim, ph2_lim, jump, elapsed, remain, ext;
  logic          lock_q, lock_d;
  logic          bit_q, bit_d;
  logic          start, samp;

  assign ph1_lim = QW'(ph1_i);
  assign ph2_lim = QW'(ph2_i);
  assign jump    = QW'(sjw_i) + 1'b1;
  assign elapsed = cnt_q + 1'b1;
  assign remain  = lim_q - cnt_q + 1'b1;
  assign ext     = (elapsed < jump) ? elapsed : jump;

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    lock_d  = lock_q;
    lim_eff = lim_q;
    start   = 1'b0;
    samp    = 1'b0;
    if (tick_i) begin
      if (fall_i && hsync_en_i) begin
        start  = 1'b1;
        seg_d  = SEG_PH1;
        cnt_d  = '0;
        lim_d  = ph1_lim;
        lock_d = 1'b1;
      end else begin
        case (seg_q)
          SEG_SYNC: begin
            start = 1'b1;
            seg_d = SEG_PH1;
            cnt_d = '0;
            lim_d = ph1_lim;
          end
          SEG_PH1: begin
            if (fall_i && !lock_q) begin
              lim_eff = lim_q + ext;
              lock_d  = 1'b1;
            end
            if (cnt_q >= lim_eff) begin
              samp   = 1'b1;
              seg_d  = SEG_PH2;
              cnt_d  = '0;
              lim_d  = ph2_lim;
              lock_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
              lim_d = lim_eff;
            end
          end
          SEG_PH2: begin
            if (fall_i && !lock_q) begin
              lock_d = 1'b1;
              if (remain <= jump) begin
                start = 1'b1;
                seg_d = SEG_PH1;
                cnt_d = '0;
                lim_d = ph1_lim;
              end else begin
                lim_eff = lim_q - jump;
              end
            end
            if (!start) begin
              if (cnt_q >= lim_eff) begin
                seg_d = SEG_SYNC;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
                lim_d = lim_eff;
              end
            end
          end
          default: begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_comb begin
    if (samp) bit_d = line_i;
    else      bit_d = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      lim_q  <= '0;
      lock_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      lock_q <= lock_d;
      bit_q  <= bit_d;
    end
  end

  assign start_o  = start;
  assign sample_o = samp;
  assign bit_o    = bit_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int unsigned LO_W  = BRP_LO_W,
  parameter int unsigned HI_W  = BRP_HI_W,
  parameter int unsigned P1_W  = PH1_W,
  parameter int unsigned P2_W  = PH2_W,
  parameter int unsigned JW_W  = SJW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LO_W-1:0] presc_lo_i,
  input  logic [HI_W-1:0] presc_hi_i,
  input  logic [P1_W-1:0] ph1_len_i,
  input  logic [P2_W-1:0] ph2_len_i,
  input  logic [JW_W-1:0] sjw_i,
  input  logic            rx_i,
  input  logic            hard_sync_req_i,
  input  logic            bus_idle_i,
  output logic            tq_tick_o,
  output logic            sample_o,
  output logic            rx_bit_o,
  output logic            bit_start_o
);
  logic rst_int_n;
  logic tick;
  logic line;
  logic fall;
  logic hsync_en;

  assign hsync_en = bus_idle_i | hard_sync_req_i;

  can_bt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  can_bt_prescaler #(.LO_W(LO_W), .HI_W(HI_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .lo_i   (presc_lo_i),
    .hi_i   (presc_hi_i),
    .tick_o (tick)
  );

  can_bt_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .rx_i   (rx_i),
    .tick_i (tick),
    .line_o (line),
    .fall_o (fall)
  );

  can_bt_phase #(.PH1_W(P1_W), .PH2_W(P2_W), .SJW_W(JW_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .tick_i     (tick),
    .fall_i     (fall),
    .hsync_en_i (hsync_en),
    .line_i     (line),
    .ph1_i      (ph1_len_i),
    .ph2_i      (ph2_len_i),
    .sjw_i      (sjw_i),
    .start_o    (bit_start_o),
    .sample_o   (sample_o),
    .bit_o      (rx_bit_o)
  );

  assign tq_tick_o = tick;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int unsigned LO_W = 6,
  parameter int unsigned HI_W = 4,
  parameter int unsigned P1_W = 4,
  parameter int unsigned P2_W = 3,
  parameter int unsigned JW_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [LO_W-1:0] presc_lo_i,
  input logic [HI_W-1:0] presc_hi_i,
  input logic            rx_i,
  input logic            tq_tick_o,
  input logic            sample_o,
  input logic            rx_bit_o,
  input logic            bit_start_o
);
  localparam int unsigned MAXQ  = 1 + (2**P1_W) + (2**JW_W) + (2**P2_W);
  localparam int unsigned QCW   = $clog2(MAXQ + 2);
  localparam int unsigned GAP_W = LO_W + HI_W + 1;

  logic [QCW-1:0]   q_in_bit;
  logic [1:0]       samp_in_bit;
  logic [GAP_W-1:0] gap;
  logic             seen_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_in_bit    <= '0;
      samp_in_bit <= '0;
      gap         <= '0;
      seen_tick   <= 1'b0;
    end else begin
      if (bit_start_o) q_in_bit <= '0;
      else if (tq_tick_o && q_in_bit != '1) q_in_bit <= q_in_bit + 1'b1;
      if (bit_start_o) samp_in_bit <= '0;
      else if (sample_o && samp_in_bit != 2'b11) samp_in_bit <= samp_in_bit + 1'b1;
      if (tq_tick_o) begin
        gap       <= '0;
        seen_tick <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_tick_o && seen_tick) |-> (gap == GAP_W'({presc_hi_i, presc_lo_i})));

  p_start_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |-> tq_tick_o);

  p_bit_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_in_bit <= QCW'(MAXQ));

  p_sample_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> tq_tick_o);

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, bit_start_o}));

  p_rxbit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_o) |-> $stable(rx_bit_o));

  p_rxbit_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (rx_bit_o == $past(rx_i, 2)));

  p_one_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (samp_in_bit == 2'b00));
endmodule

bind can_bit_timer can_bit_timer_chk #(
  .LO_W (LO_W),
  .HI_W (HI_W),
  .P1_W (P1_W),
  .P2_W (P2_W),
  .JW_W (JW_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .presc_lo_i  (presc_lo_i),
  .presc_hi_i  (presc_hi_i),
  .rx_i        (rx_i),
  .tq_tick_o   (tq_tick_o),
  .sample_o    (sample_o),
  .rx_bit_o    (rx_bit_o),
  .bit_start_o (bit_start_o)
);

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // prescaler high, low, phase1, phase2, bit period in cycles, sample offset in cycles
  localparam int V_HI [NVEC] = '{0, 0, 0, 1, 0, 0};
  localparam int V_LO [NVEC] = '{0, 2, 0, 0, 63, 5};
  localparam int V_P1 [NVEC] = '{1, 3, 15, 1, 2, 7};
  localparam int V_P2 [NVEC] = '{1, 2, 7, 1, 1, 4};
  localparam int V_PER[NVEC] = '{5, 24, 25, 325, 384, 84};
  localparam int V_SMP[NVEC] = '{2, 12, 16, 130, 192, 48};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] presc_lo_i = '0;
  logic [3:0] presc_hi_i = '0;
  logic [3:0] ph1_len_i = 4'd5;
  logic [2:0] ph2_len_i = 3'd3;
  logic [1:0] sjw_i = 2'd1;
  logic       rx_i = 1'b1;
  logic       hard_sync_req_i = 1'b0;
  logic       bus_idle_i = 1'b0;
  logic       tq_tick_o, sample_o, rx_bit_o, bit_start_o;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  can_bit_timer dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .presc_lo_i      (presc_lo_i),
    .presc_hi_i      (presc_hi_i),
    .ph1_len_i       (ph1_len_i),
    .ph2_len_i       (ph2_len_i),
    .sjw_i           (sjw_i),
    .rx_i            (rx_i),
    .hard_sync_req_i (hard_sync_req_i),
    .bus_idle_i      (bus_idle_i),
    .tq_tick_o       (tq_tick_o),
    .sample_o        (sample_o),
    .rx_bit_o        (rx_bit_o),
    .bit_start_o     (bit_start_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int hi, input int lo, input int p1, input int p2, input int j);
    @(negedge clk_i);
    rst_ni     = 1'b0;
    presc_hi_i = 4'(hi);
    presc_lo_i = 6'(lo);
    ph1_len_i  = 4'(p1);
    ph2_len_i  = 3'(p2);
    sjw_i      = 2'(j);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_bs();
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!bit_start_o && n < 3000);
  endtask

  // Syncs to a bit start N, then drives rx_i at negedge N+k; reports offsets of first events after 'from'.
  task automatic edge_case(input int from, input int df, input int dr, input int df2,
                           output int ts, output int tb, output int rxb);
    wait_bs();
    ts = -1; tb = -1; rxb = -1;
    for (int k = 0; k <= 60; k++) begin
      if (k > 0) begin
        @(negedge clk_i);
        if (ts >= 0 && rxb < 0 && k == ts + 1) rxb = int'(rx_bit_o);
        if (k > from && sample_o && ts < 0) ts = k;
        if (k > from && bit_start_o && tb < 0) tb = k;
      end
      if (k == df)  rx_i = 1'b0;
      if (k == dr)  rx_i = 1'b1;
      if (k == df2) rx_i = 1'b0;
    end
    rx_i = 1'b1;
    repeat (30) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ts, tb, rxb, ticks, gap;
    bit first_ok;

    // R9: reset state
    repeat (2) @(negedge clk_i);
    chk({tq_tick_o, sample_o, bit_start_o, rx_bit_o} == 4'b0, "R9 reset outputs",
        int'({tq_tick_o, sample_o, bit_start_o, rx_bit_o}), 0);
    rst_ni = 1'b1;
    first_ok = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk_i);
      if (tq_tick_o) begin
        first_ok = bit_start_o;
        break;
      end
    end
    chk(first_ok, "R9 first tick is bit start", int'(first_ok), 1);

    // R1 R2 R3: vector table, no edges
    for (int i = 0; i < NVEC; i++) begin
      apply_cfg(V_HI[i], V_LO[i], V_P1[i], V_P2[i], 1);
      wait_bs();
      ts = -1; tb = -1; ticks = 0;
      for (int k = 1; k < 2000; k++) begin
        @(negedge clk_i);
        if (tq_tick_o) ticks++;
        if (sample_o && ts < 0) ts = k;
        if (bit_start_o) begin
          tb = k;
          break;
        end
      end
      chk(tb == V_PER[i], "R2 bit period", tb, V_PER[i]);
      chk(ts == V_SMP[i], "R3 sample offset", ts, V_SMP[i]);
      chk(ticks == V_PER[i] / (V_HI[i]*64 + V_LO[i] + 1), "R1 quanta per bit", ticks,
          V_PER[i] / (V_HI[i]*64 + V_LO[i] + 1));
      gap = 0;
      do @(negedge clk_i); while (!tq_tick_o);
      do begin
        @(negedge clk_i);
        gap++;
      end while (!tq_tick_o && gap < 2000);
      chk(gap == V_HI[i]*64 + V_LO[i] + 1, "R1 tick spacing", gap, V_HI[i]*64 + V_LO[i] + 1);
    end

    // Resync cases: L1=6, L2=4, jump 2, one cycle per quantum
    apply_cfg(0, 0, 5, 3, 1);

    edge_case(0, 0, 20, -1, ts, tb, rxb);   // R5 R12: edge in quantum 1
    chk(ts == 7, "R5 lengthen by 1 sample", ts, 7);
    chk(tb == 12, "R5 lengthen by 1 bit start", tb, 12);
    chk(rxb == 0, "R4 sampled dominant", rxb, 0);

    edge_case(0, 3, 20, -1, ts, tb, rxb);   // R5: edge in quantum 4, clamped to jump 2
    chk(ts == 8, "R5 clamped sample", ts, 8);
    chk(tb == 13, "R5 clamped bit start", tb, 13);

    edge_case(0, 9, 20, -1, ts, tb, rxb);   // R6: edge in quantum 10, e=1
    chk(tb == 10, "R6 edge quantum becomes sync", tb, 10);

    edge_case(0, 6, 20, -1, ts, tb, rxb);   // R6: edge in quantum 7, e=4 > 2
    chk(tb == 9, "R6 shorten by jump", tb, 9);

    bus_idle_i = 1'b1;
    edge_case(0, 2, 20, -1, ts, tb, rxb);   // R7: idle hard sync at quantum 3
    bus_idle_i = 1'b0;
    chk(tb == 3, "R7 idle hard sync bit start", tb, 3);
    chk(ts == 9, "R7 idle hard sync sample", ts, 9);

    hard_sync_req_i = 1'b1;
    edge_case(0, 4, 20, -1, ts, tb, rxb);   // R7: requested hard sync at quantum 5
    hard_sync_req_i = 1'b0;
    chk(tb == 5, "R7 request hard sync", tb, 5);

    edge_case(0, 0, 1, 2, ts, tb, rxb);     // R8: edges at quanta 1 and 3
    chk(ts == 7, "R8 second edge ignored sample", ts, 7);
    chk(tb == 12, "R8 second edge ignored bit start", tb, 12);

    edge_case(11, 10, 20, -1, ts, tb, rxb); // R8: edge in sync quantum
    chk(ts == 17, "R8 sync quantum edge sample", ts, 17);
    chk(tb == 22, "R8 sync quantum edge bit start", tb, 22);

    rx_i = 1'b0;                            // R11: rising edge only
    repeat (40) @(negedge clk_i);
    chk(rx_bit_o == 1'b0, "R4 low line sampled", int'(rx_bit_o), 0);
    wait_bs();
    repeat (10) @(negedge clk_i);
    rx_i = 1'b0;
    edge_case(0, -1, 1, -1, ts, tb, rxb);
    chk(ts == 6, "R11 rising edge sample", ts, 6);
    chk(tb == 11, "R11 rising edge bit start", tb, 11);
    chk(rxb == 1, "R4 sampled recessive", rxb, 1);

    apply_cfg(0, 1, 5, 3, 1);               // R10: two cycles per quantum
    edge_case(0, 0, 20, -1, ts, tb, rxb);
    chk(ts == 14, "R10 held edge sample", ts, 14);
    chk(tb == 24, "R10 held edge bit start", tb, 24);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule